// File: doc/BRIEF.md
# Two-Channel Serial Controller Register and Interrupt Front End

This block is the register-access and interrupt front end of a serial controller with two channels. A host reaches it over a two-bit address: bit 0 picks channel A (0) or channel B (1), and bit 1 picks the data port (1) or the control port (0). Control registers are reached indirectly. A write to control register 0 sets a shared register pointer, and the next control access uses that pointer and then returns it to zero. Data-port reads return zero. Serial shifting, baud generation and FIFOs are not part of this block.

Each channel samples a carrier-detect level input. When the level changes and the channel's change interrupt is enabled, the channel latches a pending external/status event. The block combines the pending channels with a shared master enable to drive one active-high interrupt request. Reading register 2 through channel A returns the shared interrupt vector with a three-bit source field replaced, so the host can dispatch directly to the handler for the requesting channel.

Top module: `sio_irq_front`

## Requirements
- R1: Address bit 0 picks channel A (0) or B (1), and address bit 1 picks the data port (1) or the control port (0). Data-port reads return 0x00. Data-port accesses change no register and leave the pointer as it is.
- R2: A control write while the pointer is 0 loads the pointer from bits 2:0, and command field bits 5:3 equal to 1 adds 8 to it. A control write while the pointer is non-zero stores the value into the addressed register and returns the pointer to 0.
- R3: Every control-port read returns the pointer to 0.
- R4: Control register 0 reads the channel's carrier-detect level in bit 3, sampled one clock after the input, with all other bits 0.
- R5: When a channel's sampled carrier level changes and bit 3 of its register 15 is set, its pending flag sets and bit 3 of its readable register 15 sets. An unchanged level, or a cleared enable bit, sets nothing.
- R6: A control write to register 0 with bits 5:3 equal to 2 clears that channel's pending flag and its latched status. A carrier change in the same cycle takes precedence, so the flag stays set.
- R7: A channel requests when bit 0 of its register 1 is set and its pending flag is set. irq_out is high when bit 3 of register 9 is set and any channel requests.
- R8: Reading register 2 through channel A returns the vector with a three-bit field replaced by 1 (channel A) or 5 (channel B). Channel A has priority. The field sits at bits 3:1 when bit 4 of register 9 is 0 and at bits 6:4 when it is 1. When no channel requests, the vector is returned unchanged.
- R9: Reading register 2 through channel B returns 0x00, and any control register other than 0, 2 and 15 reads 0x00.
- R10: Registers 2 and 9 are single copies, written through either channel. Registers 1 and 15 and the latched status are held separately per channel.
- R11: A synchronous active-low reset clears the pointer, all registers, pending flags, latched status and sampled levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Bit 0 channel, bit 1 data/control select |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high |
| carrier_in | input | 2 | Carrier-detect level per channel (bit 0 = A) |
| irq_out | output | 1 | Active-high interrupt request |

## Verification
Several properties are checked on every cycle: that each pointer return happens after reads and after register writes, that the sampled carrier level follows its input, that a pending flag rises only after an enabled level change, that the clear command works, that data and channel-B vector reads return zero, and that the interrupt line is never high without a requesting channel. Only the bench scenarios can show the rest. These are the full vector rewrite values at both field positions, channel A priority when both channels are pending, that the shared registers really are shared and the per-channel registers are not, and that a level change outranks a clear in the same cycle.

// File: rtl/sio_irq_pkg.sv
// Package: constants shared by the serial interrupt front end.
// Assumes a byte-wide host bus and exactly two channels.
package sio_irq_pkg;
    localparam int DATA_W   = 8;
    localparam int NUM_CH   = 2;
    localparam int PTR_W    = 4;
    localparam int CMD_LSB  = 3;
    localparam int CMD_W    = 3;
    localparam int FIELD_W  = 3;

    // Register indices reached through the pointer
    localparam logic [PTR_W-1:0] REG_CMD    = 4'd0;
    localparam logic [PTR_W-1:0] REG_IE     = 4'd1;
    localparam logic [PTR_W-1:0] REG_VEC    = 4'd2;
    localparam logic [PTR_W-1:0] REG_MASTER = 4'd9;
    localparam logic [PTR_W-1:0] REG_EXTCTL = 4'd15;

    // Command codes in bits 5:3 of register 0
    localparam logic [CMD_W-1:0] CMD_HIGH    = 3'd1;
    localparam logic [CMD_W-1:0] CMD_CLR_EXT = 3'd2;

    // Bit positions that neighbouring logic decodes
    localparam int CD_BIT     = 3;   // carrier bit in reads and enable mask
    localparam int IE_EXT_BIT = 0;   // per-channel interrupt enable
    localparam int MIE_BIT    = 3;   // master enable
    localparam int VSEL_BIT   = 4;   // selects high field position
    localparam int FIELD_LO   = 1;
    localparam int FIELD_HI   = 4;
endpackage

// File: rtl/sio_ptr_ctl.sv
// Module: register pointer shared by both channels.
// Loads from a control write at pointer 0 and returns to 0 after any other
// control access. Assumes at most one of ctrl_wr and ctrl_rd per cycle; write wins.
module sio_ptr_ctl
    import sio_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic              ctrl_rd,
    input  logic [DATA_W-1:0] wdata,
    output logic [PTR_W-1:0]  ptr
);
    logic [PTR_W-1:0] ptr_q;
    logic             high_sel;

    // Decode the command field that adds 8 to the loaded pointer
    always_comb begin
        high_sel = (wdata[CMD_LSB +: CMD_W] == CMD_HIGH);
    end

    // Pointer register update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (ctrl_wr) begin
            if (ptr_q == REG_CMD) ptr_q <= {high_sel, wdata[PTR_W-2:0]};
            else                  ptr_q <= '0;
        end else if (ctrl_rd) begin
            ptr_q <= '0;
        end
    end

    assign ptr = ptr_q;

    AST_RD_PTR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rd && !ctrl_wr) |=> (ptr_q == '0)); // R3
    AST_WR_PTR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && ptr_q != '0) |=> (ptr_q == '0)); // R2
endmodule

// File: rtl/sio_ext_status.sv
// Module: one channel's carrier sampling, enables and external/status latch.
// Assumes carrier_in is already synchronous to clk. A level change in the same
// cycle as a clear command leaves the latch set.
module sio_ext_status
    import sio_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              carrier_in,
    input  logic              ie_we,
    input  logic              xc_we,
    input  logic              clr_ext,
    input  logic [DATA_W-1:0] wdata,
    output logic              cd_level,
    output logic [DATA_W-1:0] ext_stat,
    output logic              req
);
    logic              cd_q;
    logic              pend_q;
    logic [DATA_W-1:0] stat_q;
    logic [DATA_W-1:0] ie_q;
    logic [DATA_W-1:0] xmask_q;
    logic              cd_hit;
    logic [DATA_W-1:0] stat_nxt;

    // Detect an enabled carrier-level change
    always_comb begin
        cd_hit = (carrier_in != cd_q) && xmask_q[CD_BIT];
    end

    // Next latched status: clear first, then record a change
    always_comb begin
        stat_nxt = clr_ext ? '0 : stat_q;
        if (cd_hit) stat_nxt[CD_BIT] = 1'b1;
    end

    // Carrier sample, pending flag and latched status
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cd_q   <= 1'b0;
            pend_q <= 1'b0;
            stat_q <= '0;
        end else begin
            cd_q   <= carrier_in;
            stat_q <= stat_nxt;
            if (cd_hit)       pend_q <= 1'b1;
            else if (clr_ext) pend_q <= 1'b0;
        end
    end

    // Per-channel enable registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q    <= '0;
            xmask_q <= '0;
        end else begin
            if (ie_we) ie_q    <= wdata;
            if (xc_we) xmask_q <= wdata;
        end
    end

    assign cd_level = cd_q;
    assign ext_stat = stat_q;
    assign req      = ie_q[IE_EXT_BIT] & pend_q;

    AST_LEVEL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cd_q == $past(carrier_in))); // R4
    AST_PEND_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_q) |-> ($past(carrier_in != cd_q) && $past(xmask_q[CD_BIT]))); // R5
    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ext && !cd_hit) |=> (!pend_q && stat_q == '0)); // R6
endmodule

// File: rtl/sio_vec_merge.sv
// Module: rewrites the source field of the interrupt vector.
// The lowest-numbered requesting channel wins; its code is {ch[0], 2'b01}.
// Assumes NUM_CH is at most 2 so that codes fit the field.
module sio_vec_merge
    import sio_irq_pkg::*;
(
    input  logic [DATA_W-1:0] vec_in,
    input  logic [NUM_CH-1:0] req,
    input  logic              hi_pos,
    output logic [DATA_W-1:0] vec_out
);
    logic [FIELD_W-1:0] code;
    logic               any_req;

    // Priority pick, scanning downward so channel 0 is applied last
    always_comb begin
        code    = '0;
        any_req = 1'b0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (req[i]) begin
                code    = {i[0], 2'b01};
                any_req = 1'b1;
            end
        end
    end

    // Insert the code at the selected position
    always_comb begin
        vec_out = vec_in;
        if (any_req) begin
            if (hi_pos) vec_out[FIELD_HI +: FIELD_W] = code;
            else        vec_out[FIELD_LO +: FIELD_W] = code;
        end
    end
endmodule

// File: rtl/sio_irq_front.sv
// Module: top of the register-access and interrupt front end.
// Decodes the host bus, holds the shared vector and master registers,
// instantiates one status block per channel and builds the read data.
// Assumes one bus access (read or write) per cycle.
module sio_irq_front
    import sio_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [1:0]        carrier_in,
    output logic              irq_out
);
    logic              ch_sel;
    logic              ctrl_wr;
    logic              ctrl_rd;
    logic [PTR_W-1:0]  ptr;
    logic [DATA_W-1:0] vec_q;
    logic [DATA_W-1:0] master_q;
    logic [DATA_W-1:0] vec_view;
    logic [NUM_CH-1:0] req;
    logic [NUM_CH-1:0] cd_level;
    logic [DATA_W-1:0] ext_stat [NUM_CH];
    logic [DATA_W-1:0] ctrl_val;
    logic              clr_cmd;

    // Bus decode
    always_comb begin
        ch_sel  = bus_addr[0];
        ctrl_wr = bus_wr && !bus_addr[1];
        ctrl_rd = bus_rd && !bus_addr[1];
        clr_cmd = ctrl_wr && (ptr == REG_CMD)
                  && (bus_wdata[CMD_LSB +: CMD_W] == CMD_CLR_EXT);
    end

    sio_ptr_ctl u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_wr (ctrl_wr),
        .ctrl_rd (ctrl_rd),
        .wdata   (bus_wdata),
        .ptr     (ptr)
    );

    // Shared vector and master registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q    <= '0;
            master_q <= '0;
        end else if (ctrl_wr) begin
            if (ptr == REG_VEC)    vec_q    <= bus_wdata;
            if (ptr == REG_MASTER) master_q <= bus_wdata;
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic hit;
        assign hit = (ch_sel == c[0]);
        sio_ext_status u_stat (
            .clk        (clk),
            .rst_n      (rst_n),
            .carrier_in (carrier_in[c]),
            .ie_we      (ctrl_wr && hit && ptr == REG_IE),
            .xc_we      (ctrl_wr && hit && ptr == REG_EXTCTL),
            .clr_ext    (clr_cmd && hit),
            .wdata      (bus_wdata),
            .cd_level   (cd_level[c]),
            .ext_stat   (ext_stat[c]),
            .req        (req[c])
        );
    end

    sio_vec_merge u_vec (
        .vec_in  (vec_q),
        .req     (req),
        .hi_pos  (master_q[VSEL_BIT]),
        .vec_out (vec_view)
    );

    // Control read multiplexer
    always_comb begin
        ctrl_val = '0;
        case (ptr)
            REG_CMD:    ctrl_val[CD_BIT] = cd_level[ch_sel];
            REG_VEC:    ctrl_val = ch_sel ? '0 : vec_view;
            REG_EXTCTL: ctrl_val = ext_stat[ch_sel];
            default:    ctrl_val = '0;
        endcase
    end

    assign bus_rdata = ctrl_rd ? ctrl_val : '0;
    assign irq_out   = master_q[MIE_BIT] && (|req);

    AST_DATA_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr[1]) |-> (bus_rdata == '0)); // R1
    AST_B_VEC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 2'b01 && ptr == REG_VEC) |-> (bus_rdata == '0)); // R9
    AST_IRQ_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (req != '0)); // R7
endmodule

// File: tb/sio_irq_front_test.sv
module sio_irq_front_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [1:0] carrier_in = '0;
    logic       irq_out;

    int n_checks = 0;
    int n_fails  = 0;
    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #10 clk = ~clk;

    sio_irq_front uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .carrier_in(carrier_in), .irq_out(irq_out)
    );

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    // Monitor: pops expected read data and compares mid-cycle
    always @(negedge clk) begin
        if (rst_n && bus_rd) begin
            n_checks++;
            if (exp_q.size() == 0) begin
                n_fails++;
                $display("FAIL unexpected read: actual %02h expected none", bus_rdata);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (bus_rdata !== e) begin
                    n_fails++;
                    $display("FAIL %s: actual %02h expected %02h", t, bus_rdata, e);
                end
            end
        end
    end

    // One bus cycle; called at posedge+2 and returns at the next posedge+2
    task automatic bus_op(input bit wr, input bit data, input bit ch, input logic [7:0] v);
        bus_addr  = {data, ch};
        bus_wdata = v;
        bus_wr    = wr;
        bus_rd    = !wr;
        @(posedge clk); #2;
        bus_wr = 1'b0;
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2;
        end
    endtask

    task automatic wr_reg(input bit ch, input logic [3:0] r, input logic [7:0] v);
        if (r != 0) bus_op(1'b1, 1'b0, ch, {4'h0, r});
        bus_op(1'b1, 1'b0, ch, v);
    endtask

    task automatic expect_rd(input bit data, input bit ch, input logic [7:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        bus_op(1'b0, data, ch, 8'h00);
    endtask

    task automatic rd_reg(input bit ch, input logic [3:0] r, input logic [7:0] e, input string t);
        if (r != 0) bus_op(1'b1, 1'b0, ch, {4'h0, r});
        expect_rd(1'b0, ch, e, t);
    endtask

    task automatic chk_irq(input logic e, input string t);
        n_checks++;
        if (irq_out !== e) begin
            n_fails++;
            $display("FAIL %s irq: actual %0b expected %0b", t, irq_out, e);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        chk_irq(1'b0, "R11 reset");
        rd_reg(0, 0, 8'h00, "R11 reg0 after reset");
        rd_reg(0, 2, 8'h00, "R11 vector after reset");
        wr_reg(1, 2, 8'hA0);                        // shared vector via B
        rd_reg(0, 2, 8'hA0, "R10 vector shared");
        rd_reg(1, 2, 8'h00, "R9 vector via B");
        wr_reg(0, 5, 8'hFF);
        rd_reg(0, 5, 8'h00, "R9 unlisted reg");
        bus_op(1'b1, 1'b0, 0, 8'h02);
        expect_rd(1'b0, 0, 8'hA0, "R2 pointer load");
        expect_rd(1'b0, 0, 8'h00, "R3 pointer back to 0");
        bus_op(1'b1, 1'b0, 0, 8'h02);
        bus_op(1'b1, 1'b1, 0, 8'h55);               // data write, no effect
        expect_rd(1'b1, 0, 8'h00, "R1 data read zero");
        expect_rd(1'b0, 0, 8'hA0, "R1 data access keeps pointer");
        // channel A change interrupt
        wr_reg(0, 15, 8'h08);
        wr_reg(0, 1, 8'h01);
        wr_reg(1, 9, 8'h08);
        carrier_in[0] = 1'b1;
        idle(1);
        chk_irq(1'b1, "R7 A request");
        rd_reg(0, 0, 8'h08, "R4 carrier level A");
        rd_reg(0, 15, 8'h08, "R5 latched change A");
        rd_reg(0, 2, 8'hA2, "R8 A low field");
        rd_reg(1, 0, 8'h00, "R1 channel B select");
        wr_reg(0, 9, 8'h18);
        rd_reg(0, 2, 8'h90, "R8 A high field");
        wr_reg(0, 0, 8'h10);
        chk_irq(1'b0, "R6 clear A");
        rd_reg(0, 15, 8'h00, "R6 status cleared");
        rd_reg(0, 0, 8'h08, "R4 level held");
        idle(3);
        chk_irq(1'b0, "R5 unchanged level");
        // channel B
        wr_reg(1, 15, 8'h08);
        wr_reg(1, 1, 8'h01);
        carrier_in[1] = 1'b1;
        idle(1);
        chk_irq(1'b1, "R7 B request");
        rd_reg(0, 2, 8'hD0, "R8 B high field");
        wr_reg(1, 9, 8'h08);
        rd_reg(0, 2, 8'hAA, "R8 B low field");
        carrier_in[0] = 1'b0;
        idle(1);
        rd_reg(0, 2, 8'hA2, "R8 A priority");
        rd_reg(1, 15, 8'h08, "R10 B status separate");
        wr_reg(0, 9, 8'h00);
        chk_irq(1'b0, "R7 master off");
        rd_reg(0, 2, 8'hA2, "R8 rewrite without master");
        wr_reg(0, 0, 8'h10);
        wr_reg(1, 0, 8'h10);
        wr_reg(0, 9, 8'h08);
        // enable mask clear
        wr_reg(0, 15, 8'h00);
        carrier_in[0] = 1'b1;
        idle(1);
        rd_reg(0, 15, 8'h00, "R5 mask clear ignores change");
        chk_irq(1'b0, "R5 no request");
        // per-channel enable clear
        wr_reg(0, 15, 8'h08);
        wr_reg(0, 1, 8'h00);
        carrier_in[0] = 1'b0;
        idle(1);
        rd_reg(0, 15, 8'h08, "R7 pending latched");
        chk_irq(1'b0, "R7 enable off");
        rd_reg(0, 2, 8'hA0, "R8 no request unchanged");
        wr_reg(0, 1, 8'h01);
        chk_irq(1'b1, "R7 enable on");
        // change and clear in same cycle
        carrier_in[0] = 1'b1;
        wr_reg(0, 0, 8'h10);
        chk_irq(1'b1, "R6 change wins");
        rd_reg(0, 15, 8'h08, "R6 status kept");
        // mid-run reset
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        chk_irq(1'b0, "R11 reset irq");
        rd_reg(0, 15, 8'h00, "R11 status cleared");
        rd_reg(0, 2, 8'h00, "R11 vector cleared");
        rd_reg(0, 0, 8'h08, "R4 level after reset");
        idle(2);
        if (exp_q.size() != 0) begin
            n_checks++;
            n_fails++;
            $display("FAIL scoreboard: actual %0d left expected 0", exp_q.size());
        end
        finish_run();
    end
endmodule